// File: doc/BRIEF.md
# Colour Character Raster Generator

The block turns a character grid held in external memory into a serial pixel stream for a display. It walks a raster made of character cells eight pixels wide and eight scan lines tall. For every cell it reads three bytes from memory at one shared cell address: a character code, a foreground colour and a background colour. The character code and the scan line within the character row select one row of an internal 8x8 glyph pattern. That row is shifted out one pixel per clock. Each glyph bit picks one of the two per-cell colours.

The grid includes cells for blanking and sync. By default it is 64 columns by 32 character rows, of which 51 by 30 are shown, for a 408x240 visible image. Memory is read one cell ahead of the one on screen, so the memory sees one access per eight pixel clocks. The colour byte and both sync lines leave through a single register stage, which keeps glitches off the display. Arbitration of the memory between this block and other masters is outside the block, and so is the analog conversion.

Top module: `txt_pixgen`

## Requirements
- R1: While reset is asserted, `pix_color`, `hsync` and `vsync` are all 0. The raster counters rest at pixel 0 of column 0, scan line 0, character row 0, so `mem_addr` is 1.
- R2: The raster advances one pixel per clock. It moves through pixels 0..7 within a cell, then through columns 0..COLS_TOTAL-1, then through scan lines 0..7 of a character row, then through character rows 0..ROWS_TOTAL-1, and then wraps. Reset is released by an internal two-stage synchronizer. The output for the n-th raster position (n = 0 at the origin) is presented after the (n+3)-th rising edge that follows the release of `rst_n`.
- R3: `mem_addr` always equals row*COLS_TOTAL+column of the cell that follows the current cell in raster order. After the last column it wraps to column 0 of the next scan line, and after the last scan line of the last row it wraps to the frame origin.
- R4: `chr_code`, `fg_col` and `bg_col` are sampled only at the rising edge where the current pixel is pixel 7 of its cell. Values they carry at any other edge have no effect on the outputs.
- R5: The built-in glyph row for code c and scan line l (0..7) is rotate-left-by-l of c, XOR-ed with l*0x11. Bit 7 of that row is pixel 0, the leftmost pixel of the cell.
- R6: Inside the visible area, a set glyph bit outputs the cell's foreground colour and a clear bit outputs its background colour.
- R7: A cell whose column is at least COLS_VIS, or whose character row is at least ROWS_VIS, outputs colour 0.
- R8: `hsync` is high, on every scan line, for the cells whose column lies in HS_START up to HS_START+HS_CELLS-1, and low elsewhere.
- R9: `vsync` is high for the character rows from VS_START up to VS_START+VS_ROWS-1, and low elsewhere.
- R10: `pix_color`, `hsync` and `vsync` come from one register stage and refer to the same raster position. The first cell after reset release has had no fetch, so it outputs colour 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_addr | output | ADDR_W | Cell address of the next cell, shared by the code, foreground and background regions |
| chr_code | input | 8 | Character code read at `mem_addr` |
| fg_col | input | 8 | Foreground colour read at `mem_addr` |
| bg_col | input | 8 | Background colour read at `mem_addr` |
| hsync | output | 1 | Registered horizontal sync, active high |
| vsync | output | 1 | Registered vertical sync, active high |
| pix_color | output | 8 | Registered pixel colour, 0 outside the visible area |

## Verification
The assertions assume that the memory presents the data for `mem_addr` by the edge that ends pixel 7 of a cell. They also assume that the sync windows and visible extents lie inside the total grid, with COLS_VIS below COLS_TOTAL. They assume nothing about the data bytes on other cycles. The bench models the three memory regions as arithmetic functions of the address and a pattern seed that changes during vertical blanking. It returns bit-inverted bytes on every cycle except the sampling one, so a fetch at the wrong moment cannot go unnoticed. It runs a reduced 12x6 cell grid for three full frames and compares every pixel and every address.

// File: rtl/txpg_pkg.sv
package txpg_pkg;

  localparam int CELL_PX    = 8;
  localparam int GLYPH_ROWS = 8;
  localparam int COLOR_W    = 8;
  localparam int CODE_W     = 8;
  localparam int PX_W       = $clog2(CELL_PX);
  localparam int LINE_W     = $clog2(GLYPH_ROWS);

  typedef logic [COLOR_W-1:0] color_t;
  typedef logic [CELL_PX-1:0] glyph_row_t;

  // Computed font: rotate the code left by the scan line, then mix in the
  // scan line replicated in both nibbles.
  function automatic glyph_row_t glyph_row(input logic [CODE_W-1:0] code,
                                           input logic [LINE_W-1:0] line);
    logic [2*CODE_W-1:0] dbl;
    glyph_row_t          mix;
    dbl = {code, code} << line;
    mix = {1'b0, line, 1'b0, line};
    return dbl[2*CODE_W-1:CODE_W] ^ mix;
  endfunction

endpackage

// File: rtl/txpg_rst_sync.sv
module txpg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      hold_q  <= stage_q;
    end
  end

  assign rst_sync_n = hold_q;

endmodule

// File: rtl/txpg_timing.sv
module txpg_timing
  import txpg_pkg::*;
#(
  parameter int COLS_TOTAL = 64,
  parameter int COLS_VIS   = 51,
  parameter int ROWS_TOTAL = 32,
  parameter int ROWS_VIS   = 30,
  parameter int HS_START   = 54,
  parameter int HS_CELLS   = 6,
  parameter int VS_START   = 30,
  parameter int VS_ROWS    = 1,
  localparam int COL_W     = $clog2(COLS_TOTAL),
  localparam int ROW_W     = $clog2(ROWS_TOTAL),
  localparam int ADDR_W    = $clog2(COLS_TOTAL * ROWS_TOTAL)
) (
  input  logic              clk,
  input  logic              rst_ni,
  output logic [COL_W-1:0]  col_o,
  output logic [ROW_W-1:0]  crow_o,
  output logic              load_o,
  output logic [LINE_W-1:0] nxt_line_o,
  output logic              nxt_vis_o,
  output logic              cur_vis_o,
  output logic              hs_raw_o,
  output logic              vs_raw_o,
  output logic [ADDR_W-1:0] addr_o
);

  localparam logic [PX_W-1:0]   PX_LAST   = PX_W'(CELL_PX - 1);
  localparam logic [COL_W-1:0]  COL_LAST  = COL_W'(COLS_TOTAL - 1);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(GLYPH_ROWS - 1);
  localparam logic [ROW_W-1:0]  ROW_LAST  = ROW_W'(ROWS_TOTAL - 1);
  localparam logic [COL_W:0]    COL_VIS_L = (COL_W+1)'(COLS_VIS);
  localparam logic [ROW_W:0]    ROW_VIS_L = (ROW_W+1)'(ROWS_VIS);
  localparam logic [COL_W:0]    HS_LO     = (COL_W+1)'(HS_START);
  localparam logic [COL_W:0]    HS_HI     = (COL_W+1)'(HS_START + HS_CELLS);
  localparam logic [ROW_W:0]    VS_LO     = (ROW_W+1)'(VS_START);
  localparam logic [ROW_W:0]    VS_HI     = (ROW_W+1)'(VS_START + VS_ROWS);

  logic [PX_W-1:0]   px_q,   px_d;
  logic [COL_W-1:0]  col_q,  col_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic [ROW_W-1:0]  crow_q, crow_d;

  logic cell_end, col_wrap, line_wrap;
  logic col_en, line_en, crow_en;
  logic [LINE_W-1:0] nxt_line;
  logic [ROW_W-1:0]  nxt_crow;

  // Next-state logic
  always_comb begin
    cell_end  = (px_q == PX_LAST);
    col_wrap  = (col_q == COL_LAST);
    line_wrap = (line_q == LINE_LAST);
    col_en    = cell_end;
    line_en   = cell_end && col_wrap;
    crow_en   = line_en && line_wrap;

    px_d   = cell_end  ? '0 : px_q + PX_W'(1);
    col_d  = col_wrap  ? '0 : col_q + COL_W'(1);
    line_d = line_wrap ? '0 : line_q + LINE_W'(1);
    crow_d = (crow_q == ROW_LAST) ? '0 : crow_q + ROW_W'(1);

    // position of the cell after the current one
    nxt_line = col_wrap ? line_d : line_q;
    nxt_crow = (col_wrap && line_wrap) ? crow_d : crow_q;
  end

  // State registers with explicit enables
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      px_q   <= '0;
      col_q  <= '0;
      line_q <= '0;
      crow_q <= '0;
    end else begin
      px_q <= px_d;
      if (col_en)  col_q  <= col_d;
      if (line_en) line_q <= line_d;
      if (crow_en) crow_q <= crow_d;
    end
  end

  always_comb begin
    load_o     = cell_end;
    nxt_line_o = nxt_line;
    nxt_vis_o  = ({1'b0, col_d} < COL_VIS_L) && ({1'b0, nxt_crow} < ROW_VIS_L);
    cur_vis_o  = ({1'b0, col_q} < COL_VIS_L) && ({1'b0, crow_q} < ROW_VIS_L);
    hs_raw_o   = ({1'b0, col_q} >= HS_LO) && ({1'b0, col_q} < HS_HI);
    vs_raw_o   = ({1'b0, crow_q} >= VS_LO) && ({1'b0, crow_q} < VS_HI);
    addr_o     = ADDR_W'(nxt_crow) * ADDR_W'(COLS_TOTAL) + ADDR_W'(col_d);
    col_o      = col_q;
    crow_o     = crow_q;
  end

  AST_ROW_WRAP: assert property (@(posedge clk) disable iff (!rst_ni)
    (px_q == PX_LAST && col_q == COL_LAST) |=> (px_q == '0 && col_q == '0)); // R2

  AST_CROW_STEADY: assert property (@(posedge clk) disable iff (!rst_ni)
    !(px_q == PX_LAST && col_q == COL_LAST && line_q == LINE_LAST) |=> $stable(crow_q)); // R2

endmodule

// File: rtl/txpg_font.sv
module txpg_font
  import txpg_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  logic [LINE_W-1:0] line_i,
  output glyph_row_t        row_o
);

  always_comb row_o = glyph_row(code_i, line_i);

endmodule

// File: rtl/txpg_pixel.sv
module txpg_pixel
  import txpg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic       nxt_vis_i,
  input  glyph_row_t glyph_i,
  input  color_t     fg_i,
  input  color_t     bg_i,
  input  logic       hs_i,
  input  logic       vs_i,
  output color_t     color_o,
  output logic       hsync_o,
  output logic       vsync_o
);

  glyph_row_t shf_q, shf_d;
  color_t     fg_q,  fg_d;
  color_t     bg_q,  bg_d;
  logic       vis_q, vis_d;
  color_t     pix_d, pix_q;
  logic       hs_q, vs_q;

  // Next-state logic: load the following cell on the last pixel, else shift
  always_comb begin
    shf_d = load_i ? glyph_i : {shf_q[CELL_PX-2:0], 1'b0};
    fg_d  = load_i ? fg_i : fg_q;
    bg_d  = load_i ? bg_i : bg_q;
    vis_d = load_i ? nxt_vis_i : vis_q;
    pix_d = vis_q ? (shf_q[CELL_PX-1] ? fg_q : bg_q) : '0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      shf_q <= '0;
      fg_q  <= '0;
      bg_q  <= '0;
      vis_q <= 1'b0;
      pix_q <= '0;
      hs_q  <= 1'b0;
      vs_q  <= 1'b0;
    end else begin
      shf_q <= shf_d;
      fg_q  <= fg_d;
      bg_q  <= bg_d;
      vis_q <= vis_d;
      pix_q <= pix_d;
      hs_q  <= hs_i;
      vs_q  <= vs_i;
    end
  end

  assign color_o = pix_q;
  assign hsync_o = hs_q;
  assign vsync_o = vs_q;

  AST_HOLD_CELL: assert property (@(posedge clk) disable iff (!rst_ni)
    !load_i |=> ($stable(fg_q) && $stable(bg_q) && $stable(vis_q))); // R4

endmodule

// File: rtl/txt_pixgen.sv
module txt_pixgen
  import txpg_pkg::*;
#(
  parameter int COLS_TOTAL = 64,
  parameter int COLS_VIS   = 51,
  parameter int ROWS_TOTAL = 32,
  parameter int ROWS_VIS   = 30,
  parameter int HS_START   = 54,
  parameter int HS_CELLS   = 6,
  parameter int VS_START   = 30,
  parameter int VS_ROWS    = 1,
  localparam int COL_W     = $clog2(COLS_TOTAL),
  localparam int ROW_W     = $clog2(ROWS_TOTAL),
  localparam int ADDR_W    = $clog2(COLS_TOTAL * ROWS_TOTAL)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        chr_code,
  input  logic [7:0]        fg_col,
  input  logic [7:0]        bg_col,
  output logic              hsync,
  output logic              vsync,
  output logic [7:0]        pix_color
);

  localparam logic [COL_W:0] HS_LO_T = (COL_W+1)'(HS_START);
  localparam logic [COL_W:0] HS_HI_T = (COL_W+1)'(HS_START + HS_CELLS);

  logic              rst_sync_n;
  logic [COL_W-1:0]  col;
  logic [ROW_W-1:0]  crow;
  logic              load;
  logic [LINE_W-1:0] nxt_line;
  logic              nxt_vis;
  logic              cur_vis;
  logic              hs_raw;
  logic              vs_raw;
  glyph_row_t        glyph;
  logic              hs_win;

  txpg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  txpg_timing #(
    .COLS_TOTAL (COLS_TOTAL),
    .COLS_VIS   (COLS_VIS),
    .ROWS_TOTAL (ROWS_TOTAL),
    .ROWS_VIS   (ROWS_VIS),
    .HS_START   (HS_START),
    .HS_CELLS   (HS_CELLS),
    .VS_START   (VS_START),
    .VS_ROWS    (VS_ROWS)
  ) u_timing (
    .clk        (clk),
    .rst_ni     (rst_sync_n),
    .col_o      (col),
    .crow_o     (crow),
    .load_o     (load),
    .nxt_line_o (nxt_line),
    .nxt_vis_o  (nxt_vis),
    .cur_vis_o  (cur_vis),
    .hs_raw_o   (hs_raw),
    .vs_raw_o   (vs_raw),
    .addr_o     (mem_addr)
  );

  txpg_font u_font (
    .code_i (chr_code),
    .line_i (nxt_line),
    .row_o  (glyph)
  );

  txpg_pixel u_pixel (
    .clk       (clk),
    .rst_ni    (rst_sync_n),
    .load_i    (load),
    .nxt_vis_i (nxt_vis),
    .glyph_i   (glyph),
    .fg_i      (fg_col),
    .bg_i      (bg_col),
    .hs_i      (hs_raw),
    .vs_i      (vs_raw),
    .color_o   (pix_color),
    .hsync_o   (hsync),
    .vsync_o   (vsync)
  );

  always_comb hs_win = ({1'b0, col} >= HS_LO_T) && ({1'b0, col} < HS_HI_T);

  AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pix_color != '0) |-> $past(cur_vis)); // R7

  AST_HSYNC_WINDOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hsync == $past(hs_win)); // R8

endmodule

// File: tb/txt_pixgen_tb.sv
`timescale 1ns/1ps
module txt_pixgen_tb;

  localparam int CT    = 12;
  localparam int CV    = 9;
  localparam int RT    = 6;
  localparam int RV    = 4;
  localparam int HS0   = 10;
  localparam int HSN   = 1;
  localparam int VS0   = 5;
  localparam int VSN   = 1;
  localparam int HP    = CT * 8;
  localparam int VL    = RT * 8;
  localparam int FRAME = HP * VL;
  localparam int AW    = $clog2(CT * RT);

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] mem_addr;
  logic [7:0]    chr_code, fg_col, bg_col;
  logic          hsync, vsync;
  logic [7:0]    pix_color;

  logic [7:0] pat;
  logic       garble;
  logic       done;
  int         n_cmp;
  int         n_bad;

  txt_pixgen #(
    .COLS_TOTAL (CT), .COLS_VIS (CV), .ROWS_TOTAL (RT), .ROWS_VIS (RV),
    .HS_START (HS0), .HS_CELLS (HSN), .VS_START (VS0), .VS_ROWS (VSN)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .mem_addr (mem_addr),
    .chr_code (chr_code), .fg_col (fg_col), .bg_col (bg_col),
    .hsync (hsync), .vsync (vsync), .pix_color (pix_color)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int m_code(int a, int p);
    return (a * 5 + p) & 255;
  endfunction
  function automatic int m_fg(int a, int p);
    return (a ^ p ^ 8'h3C) & 255;
  endfunction
  function automatic int m_bg(int a, int p);
    return (a + 128 + p * 3) & 255;
  endfunction
  // R5 glyph: rotate left by line, xor line*0x11
  function automatic int exp_glyph(int c, int l);
    int r;
    r = ((c << l) | (c >> (8 - l))) & 255;
    return r ^ (l * 17);
  endfunction

  // Memory model; inverted bytes whenever the DUT must not sample (R4)
  always_comb begin
    chr_code = 8'(m_code(int'(mem_addr), int'(pat)));
    fg_col   = 8'(m_fg(int'(mem_addr), int'(pat)));
    bg_col   = 8'(m_bg(int'(mem_addr), int'(pat)));
    if (garble) begin
      chr_code = ~chr_code;
      fg_col   = ~fg_col;
      bg_col   = ~bg_col;
    end
  end

  task automatic chk(input string tag, input int pos, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s pos=%0d actual=%0h expected=%0h", tag, pos, act, exp);
    end
  endtask

  initial begin
    done = 1'b0;
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    n_cmp  = 0;
    n_bad  = 0;
    rst_n  = 1'b0;
    pat    = 8'h21;
    garble = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 colour", -1, int'(pix_color), 0);
    chk("R1 hsync", -1, int'(hsync), 0);
    chk("R1 vsync", -1, int'(vsync), 0);
    chk("R1 addr", -1, int'(mem_addr), 1);
    rst_n = 1'b1;

    for (int k = 1; k <= 3 * FRAME + 3; k++) begin
      int m, x, y, nc, ny, n, f, col, px, crow, sl, a, g, ec;
      @(posedge clk);
      @(negedge clk);
      // DUT raster position after edge k
      m = (k < 2) ? 0 : k - 2;
      garble = ((m % 8) != 7);  // R4 data valid only on pixel 7
      x  = (m % FRAME) % HP;
      y  = (m % FRAME) / HP;
      nc = x / 8 + 1;
      ny = y;
      if (nc == CT) begin
        nc = 0;
        ny = (y + 1) % VL;
      end
      chk("R3 next-cell addr", m, int'(mem_addr), (ny / 8) * CT + nc);

      if (k >= 3) begin
        n    = k - 3;  // R2 output latency of three edges
        f    = n % FRAME;
        col  = (f % HP) / 8;
        px   = (f % HP) % 8;
        crow = (f / HP) / 8;
        sl   = (f / HP) % 8;
        if (n < 8) begin
          chk("R10 first cell black", n, int'(pix_color), 0);
        end else if (col < CV && crow < RV) begin
          a  = crow * CT + col;
          g  = exp_glyph(m_code(a, int'(pat)), sl);
          ec = ((g >> (7 - px)) & 1) ? m_fg(a, int'(pat)) : m_bg(a, int'(pat));
          chk("R6_R5 visible colour", n, int'(pix_color), ec);
        end else begin
          chk("R7 blanked colour", n, int'(pix_color), 0);
        end
        chk("R8 hsync", n, int'(hsync), (col >= HS0 && col < HS0 + HSN) ? 1 : 0);
        chk("R9 vsync", n, int'(vsync), (crow >= VS0 && crow < VS0 + VSN) ? 1 : 0);
        if (f == RV * 8 * HP) pat = pat + 8'd37;  // new pattern in vertical blanking
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule